// File: doc/BRIEF.md
# Paged Segment Address Relocation Unit

The unit sits between a processor core and its physical bus. It turns a 16-bit virtual address into an 18-bit or 22-bit physical address. The virtual space is cut into eight 8 KB pages. Each page has its own base register, which relocates the page in 64-byte blocks, and its own descriptor register, which limits how far into the page a reference may reach and what kind of access it may make. Register banks exist for kernel, supervisor and user mode. In each mode, instruction fetches and data references can have separate banks. A reference that breaks the rules of its page is aborted in the same cycle.

Translation is combinational from the request to the physical address and the abort flag. Software loads the mapping registers, a control word and a fault status word through a small register port with an 8-bit register index. A register write takes effect from the next clock edge. The first abort after the status word is cleared is latched with its page, mode, space and reason. The fault recorder is a two-state machine: OPEN (no fault held) and HELD (a fault is latched). Its transitions are:

- OPEN -> HELD on a valid aborting request with no clear in the same cycle.
- HELD -> OPEN on a write to the status register.
- OPEN -> OPEN and HELD -> HELD otherwise.

Top module: `page_reloc_unit`

## Requirements
- R1: When the control word has bit 0 = 1 and bit 1 = 0, the physical address is {4'b0, (base[11:0] + va[12:6]) mod 4096, va[5:0]}. It is formed in the same cycle as the request, and it is formed whether or not the request aborts.
- R2: When the control word has bit 0 = 1 and bit 1 = 1, the physical address is {(base[15:0] + va[12:6]) mod 65536, va[5:0]}.
- R3: The page field va[15:13] selects the base/descriptor pair with that page number in the active bank.
- R4: The access field is descriptor bits [2:1]. The values 00 and 10 mean no access, and any reference aborts. The value 01 means read-only, and a write (req_write = 1) aborts. The value 11 means read-write.
- R5: The length field is descriptor bits [14:8]. A reference whose block number va[12:6] is greater than the length field aborts. A block number equal to the length field is legal.
- R6: The bank is chosen by req_mode (00 kernel, 01 supervisor, 11 user) and by req_data (0 instruction fetch, 1 data). req_mode = 10 always aborts when translation is on, and it is reported as no access.
- R7: Control bits 2, 3 and 4 enable a separate data bank for kernel, supervisor and user mode respectively. When the bit for the current mode is clear, a data reference uses that mode's instruction bank.
- R8: When control bit 0 = 0, no reference aborts. An address below 0xE000 passes through zero-extended. An address at or above 0xE000 maps onto the top 8 KB of the physical space: {4'b0, 2'b11, va} when control bit 1 = 0, and {6'h3F, va} when control bit 1 = 1.
- R9: abort is high only while req_valid is high, in the same cycle as the faulting request.
- R10: The status register is at index 0x81. Its layout is [15] valid, [8] length fault, [7] write to a read-only page, [6] no access, [5] req_data, [4:3] req_mode, [2:0] page. The first abort while the valid bit is 0 is captured, and the word then holds until it is cleared. Any write to 0x81 clears it, and a clear wins over an abort in the same cycle.
- R11: Register index bit 7 = 0 addresses a mapping register: [6:5] mode, [4] space (1 = data), [3] kind (0 base, 1 descriptor), [2:0] page. Index 0x80 is the control word, whose bits [4:0] are kept and read back zero-extended. Every register reads back what was written. A write takes effect on the cycle after it is accepted. Writes to mode 10 are ignored, and that mode reads as 0.
- R12: After reset, all mapping registers, the control word and the status word are zero, and translation is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | A reference is presented |
| req_va | input | 16 | Virtual address |
| req_write | input | 1 | 1 = write reference |
| req_data | input | 1 | 1 = data reference, 0 = instruction fetch |
| req_mode | input | 2 | Current processor mode |
| pa | output | 22 | Physical address |
| abort | output | 1 | Reference violates its page rules |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register index |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for reg_addr |

## Verification
The physical address, the abort flag and the read data are combinational. The bench therefore drives each request on a falling edge and samples these outputs a quarter period later, in the same cycle. Mapping and control writes are accepted on a rising edge, so the first request that depends on a write is presented at the following falling edge. The fault status is a register: the bench updates its model after the rising edge that ends the request and reads the word back at the next falling edge.

// File: rtl/prel_pkg.sv
package prel_pkg;
    localparam int VA_W      = 16;
    localparam int PG_W      = 3;
    localparam int BN_W      = 7;
    localparam int DISP_W    = 6;
    localparam int NPAGE     = 1 << PG_W;
    localparam int REG_W     = 16;
    localparam int PA_W      = 22;
    localparam int NARROW_PB = 12;
    localparam int NMODE     = 3;
    localparam int NBANK     = NMODE * 2;
    localparam int BK_W      = $clog2(NBANK);
    localparam int CTL_W     = 2 + NMODE;
    localparam int LEN_LO    = 8;
    localparam logic [7:0] CTL_ADDR  = 8'h80;
    localparam logic [7:0] STAT_ADDR = 8'h81;

    typedef enum logic [1:0] {
        MODE_KERN = 2'b00,
        MODE_SUPV = 2'b01,
        MODE_BAD  = 2'b10,
        MODE_USER = 2'b11
    } cpu_mode_e;

    typedef enum logic [1:0] {
        ACC_NONE  = 2'b00,
        ACC_RO    = 2'b01,
        ACC_NONE2 = 2'b10,
        ACC_RW    = 2'b11
    } acc_e;

    typedef struct packed {
        logic len_bad;
        logic ro_write;
        logic no_access;
    } fault_why_t;

    function automatic logic [1:0] mode_index(input logic [1:0] m);
        case (m)
            MODE_SUPV: return 2'd1;
            MODE_USER: return 2'd2;
            default:   return 2'd0;
        endcase
    endfunction
endpackage

// File: rtl/prel_regbank.sv
module prel_regbank
    import prel_pkg::*;
#(
    parameter int NPG = NPAGE,
    parameter int NBK = NBANK,
    parameter int RW  = REG_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [7:0]      rg_addr,
    input  logic [RW-1:0]   wr_data,
    input  logic [BK_W-1:0] bank_sel,
    input  logic [PG_W-1:0] page_sel,
    output logic [RW-1:0]   sel_base,
    output logic [RW-1:0]   sel_desc,
    output logic [RW-1:0]   map_rdata,
    output logic [CTL_W-1:0] ctl_q
);
    logic [RW-1:0] base_q [NBK][NPG];
    logic [RW-1:0] desc_q [NBK][NPG];
    logic          map_hit;
    logic [BK_W-1:0] acc_bank;
    logic [NBK-1:0][NPG-1:0] we_base;
    logic [NBK-1:0][NPG-1:0] we_desc;

    assign map_hit  = !rg_addr[7] && (rg_addr[6:5] != MODE_BAD);
    assign acc_bank = BK_W'({mode_index(rg_addr[6:5]), rg_addr[4]});

    genvar gb, gp;
    generate
        for (gb = 0; gb < NBK; gb++) begin : g_bank
            for (gp = 0; gp < NPG; gp++) begin : g_page
                assign we_base[gb][gp] = wr_en && map_hit && !rg_addr[3]
                                       && acc_bank == BK_W'(gb)
                                       && rg_addr[2:0] == PG_W'(gp);
                assign we_desc[gb][gp] = wr_en && map_hit && rg_addr[3]
                                       && acc_bank == BK_W'(gb)
                                       && rg_addr[2:0] == PG_W'(gp);
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int b = 0; b < NBK; b++) begin
                for (int p = 0; p < NPG; p++) begin
                    base_q[b][p] <= '0;
                    desc_q[b][p] <= '0;
                end
            end
        end else begin
            for (int b = 0; b < NBK; b++) begin
                for (int p = 0; p < NPG; p++) begin
                    if (we_base[b][p]) base_q[b][p] <= wr_data;
                    if (we_desc[b][p]) desc_q[b][p] <= wr_data;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else if (wr_en && rg_addr == CTL_ADDR) begin
            ctl_q <= wr_data[CTL_W-1:0];
        end
    end

    assign sel_base = base_q[bank_sel][page_sel];
    assign sel_desc = desc_q[bank_sel][page_sel];

    always_comb begin
        if (!map_hit) begin
            map_rdata = '0;
        end else if (rg_addr[3]) begin
            map_rdata = desc_q[acc_bank][rg_addr[2:0]];
        end else begin
            map_rdata = base_q[acc_bank][rg_addr[2:0]];
        end
    end

    // R11
    ctl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && rg_addr == CTL_ADDR) |=> (ctl_q == $past(wr_data[CTL_W-1:0])));
endmodule

// File: rtl/prel_xlate.sv
module prel_xlate
    import prel_pkg::*;
(
    input  logic [VA_W-1:0]  va,
    input  logic             is_write,
    input  logic             is_data,
    input  logic [1:0]       mode,
    input  logic             ctl_en,
    input  logic             ctl_wide,
    input  logic [NMODE-1:0] ctl_id,
    input  logic [REG_W-1:0] base,
    input  logic [REG_W-1:0] desc,
    output logic [BK_W-1:0]  bank_sel,
    output logic [PG_W-1:0]  page,
    output logic [PA_W-1:0]  pa,
    output logic             fault,
    output fault_why_t       why
);
    logic [BN_W-1:0]      bn;
    logic [DISP_W-1:0]    disp;
    logic [1:0]           midx;
    logic                 use_dbank;
    logic                 bad_mode;
    logic [BN_W-1:0]      len;
    acc_e                 acc;
    logic [NARROW_PB-1:0] pb_narrow;
    logic [REG_W-1:0]     pb_wide;
    logic                 top_page;
    logic                 unused_desc;

    assign page      = va[VA_W-1 -: PG_W];
    assign bn        = va[DISP_W +: BN_W];
    assign disp      = va[DISP_W-1:0];
    assign midx      = mode_index(mode);
    assign bad_mode  = (mode == MODE_BAD);
    assign use_dbank = is_data && ctl_id[midx];
    assign bank_sel  = BK_W'({midx, use_dbank});
    assign len       = desc[LEN_LO +: BN_W];
    assign acc       = acc_e'(desc[2:1]);
    assign top_page  = &page;
    assign unused_desc = ^{desc[REG_W-1], desc[LEN_LO-1:3], desc[0]};

    assign pb_narrow = base[NARROW_PB-1:0] + NARROW_PB'(bn);
    assign pb_wide   = base + REG_W'(bn);

    always_comb begin
        if (!ctl_en) begin
            if (top_page) begin
                pa = ctl_wide ? {{(PA_W-VA_W){1'b1}}, va}
                              : {4'b0, 2'b11, va};
            end else begin
                pa = PA_W'(va);
            end
        end else if (ctl_wide) begin
            pa = {pb_wide, disp};
        end else begin
            pa = {4'b0, pb_narrow, disp};
        end
    end

    always_comb begin
        why = '0;
        if (ctl_en) begin
            why.no_access = bad_mode || acc == ACC_NONE || acc == ACC_NONE2;
            why.ro_write  = !bad_mode && acc == ACC_RO && is_write;
            why.len_bad   = !bad_mode && (bn > len);
        end
    end

    assign fault = |why;
endmodule

// File: rtl/prel_fault_fsm.sv
module prel_fault_fsm
    import prel_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic            fault,
    input  fault_why_t      why,
    input  logic [PG_W-1:0] page,
    input  logic [1:0]      mode,
    input  logic            is_data,
    input  logic            clr,
    output logic [REG_W-1:0] status_q
);
    typedef enum logic {ST_OPEN = 1'b0, ST_HELD = 1'b1} fst_e;
    fst_e state, state_nx;
    logic capture;

    assign capture = (state == ST_OPEN) && req_valid && fault && !clr;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_OPEN: if (capture) state_nx = ST_HELD;
            ST_HELD: if (clr)     state_nx = ST_OPEN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OPEN;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= '0;
        end else if (clr) begin
            status_q <= '0;
        end else if (capture) begin
            status_q <= {1'b1, 6'b0, why, is_data, mode, page};
        end
    end

    // R10
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HELD && !clr) |=> $stable(status_q));
    // R10
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !status_q[REG_W-1]);
    // R10
    capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!status_q[REG_W-1] && req_valid && fault && !clr) |=> status_q[REG_W-1]);
endmodule

// File: rtl/page_reloc_unit.sv
module page_reloc_unit
    import prel_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic [15:0] req_va,
    input  logic        req_write,
    input  logic        req_data,
    input  logic [1:0]  req_mode,
    output logic [21:0] pa,
    output logic        abort,
    input  logic        reg_we,
    input  logic [7:0]  reg_addr,
    input  logic [15:0] reg_wdata,
    output logic [15:0] reg_rdata
);
    logic [BK_W-1:0]  bank_sel;
    logic [PG_W-1:0]  page;
    logic [REG_W-1:0] sel_base, sel_desc, map_rdata, status_q;
    logic [CTL_W-1:0] ctl_q;
    logic             fault, stat_clr;
    fault_why_t       why;

    assign stat_clr = reg_we && reg_addr == STAT_ADDR;

    prel_regbank u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_we), .rg_addr(reg_addr),
        .wr_data(reg_wdata), .bank_sel(bank_sel), .page_sel(page),
        .sel_base(sel_base), .sel_desc(sel_desc), .map_rdata(map_rdata),
        .ctl_q(ctl_q)
    );

    prel_xlate u_xlate (
        .va(req_va), .is_write(req_write), .is_data(req_data), .mode(req_mode),
        .ctl_en(ctl_q[0]), .ctl_wide(ctl_q[1]), .ctl_id(ctl_q[CTL_W-1:2]),
        .base(sel_base), .desc(sel_desc), .bank_sel(bank_sel), .page(page),
        .pa(pa), .fault(fault), .why(why)
    );

    prel_fault_fsm u_fault (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .fault(fault),
        .why(why), .page(page), .mode(req_mode), .is_data(req_data),
        .clr(stat_clr), .status_q(status_q)
    );

    assign abort = req_valid && fault;

    always_comb begin
        if (!reg_addr[7])                reg_rdata = map_rdata;
        else if (reg_addr == CTL_ADDR)   reg_rdata = REG_W'(ctl_q);
        else if (reg_addr == STAT_ADDR)  reg_rdata = status_q;
        else                             reg_rdata = '0;
    end

    // R8
    disabled_noabort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_q[0] |-> !abort);
    // R9
    valid_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> !abort);
endmodule

// File: tb/page_reloc_unit_bench.sv
module page_reloc_unit_bench;
    localparam int CLK_P = 10;
    localparam logic [7:0] CTL  = 8'h80;
    localparam logic [7:0] STAT = 8'h81;

    logic clk = 0, rst_n = 0;
    logic req_valid = 0, req_write = 0, req_data = 0, reg_we = 0;
    logic [15:0] req_va = 0, reg_wdata = 0, reg_rdata;
    logic [1:0]  req_mode = 0;
    logic [7:0]  reg_addr = STAT;
    logic [21:0] pa;
    logic        abort;

    int nchk = 0, nfail = 0;
    logic [15:0] mbase [6][8];
    logic [15:0] mdesc [6][8];
    logic [4:0]  mctl = 0;
    logic [15:0] mstat = 0;

    always #(CLK_P/2) clk = ~clk;

    page_reloc_unit u_page_reloc_unit (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_va(req_va),
        .req_write(req_write), .req_data(req_data), .req_mode(req_mode),
        .pa(pa), .abort(abort), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    task automatic check(input string nm, input logic [31:0] got, input logic [31:0] exp);
        nchk++;
        if (got !== exp) begin
            nfail++;
            $display("FAIL %s got %h exp %h", nm, got, exp);
        end
    endtask

    function automatic int midx(input logic [1:0] m);
        return (m == 2'b01) ? 1 : (m == 2'b11) ? 2 : 0;
    endfunction

    function automatic logic [7:0] maddr(input logic [1:0] m, input logic sp,
                                         input logic kind, input logic [2:0] pg);
        return {1'b0, m, sp, kind, pg};
    endfunction

    // returns {len, ro_write, no_access, pa}
    function automatic logic [24:0] model(input logic [15:0] va, input logic wr,
                                          input logic dat, input logic [1:0] m);
        logic [2:0] pg; logic [6:0] bn; logic [15:0] b, d;
        logic [21:0] p; logic na, ro, ln, bad; int bk;
        pg = va[15:13]; bn = va[12:6]; bad = (m == 2'b10);
        if (!mctl[0]) begin
            if (pg == 3'd7) p = mctl[1] ? {6'h3F, va} : {4'h0, 2'b11, va};
            else            p = {6'h0, va};
            return {3'b0, p};
        end
        bk = midx(m) * 2 + ((dat && mctl[2 + midx(m)]) ? 1 : 0);
        b = mbase[bk][pg]; d = mdesc[bk][pg];
        if (mctl[1]) p = {b + {9'b0, bn}, va[5:0]};
        else         p = {4'b0, b[11:0] + {5'b0, bn}, va[5:0]};
        na = bad || d[2:1] == 2'b00 || d[2:1] == 2'b10;
        ro = !bad && d[2:1] == 2'b01 && wr;
        ln = !bad && (bn > d[14:8]);
        return {ln, ro, na, p};
    endfunction

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        int bk;
        @(negedge clk);
        reg_we = 1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_we = 0; reg_addr = STAT;
        if (a == STAT) mstat = 0;
        else if (a == CTL) mctl = d[4:0];
        else if (!a[7] && a[6:5] != 2'b10) begin
            bk = midx(a[6:5]) * 2 + (a[4] ? 1 : 0);
            if (a[3]) mdesc[bk][a[2:0]] = d;
            else      mbase[bk][a[2:0]] = d;
        end
    endtask

    task automatic rd(input logic [7:0] a, input logic [15:0] exp, input string nm);
        @(negedge clk);
        reg_addr = a;
        #1 check(nm, {16'h0, reg_rdata}, {16'h0, exp});
        reg_addr = STAT;
    endtask

    task automatic do_req(input logic v, input logic [15:0] va, input logic w,
                          input logic dat, input logic [1:0] m, input logic clr,
                          input string nm);
        logic [24:0] e; logic f;
        @(negedge clk);
        req_valid = v; req_va = va; req_write = w; req_data = dat; req_mode = m;
        reg_we = clr; reg_addr = STAT; reg_wdata = 0;
        #(CLK_P/4);
        e = model(va, w, dat, m);
        f = |e[24:22];
        check({nm, " R9 abort"}, {31'h0, abort}, {31'h0, v & f});
        if (m != 2'b10) check({nm, " pa"}, {10'h0, pa}, {10'h0, e[21:0]});
        @(posedge clk); #1;
        if (clr) mstat = 0;
        else if (v && f && !mstat[15])
            mstat = {1'b1, 6'b0, e[24:22], dat, m, va[15:13]};
        req_valid = 0; reg_we = 0;
        @(negedge clk);
        #1 check({nm, " R10 status"}, {16'h0, reg_rdata}, {16'h0, mstat});
    endtask

    initial begin
        #(CLK_P * 150000);
        nfail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        for (int b = 0; b < 6; b++)
            for (int p = 0; p < 8; p++) begin mbase[b][p] = 0; mdesc[b][p] = 0; end
        repeat (3) @(posedge clk);
        #1 rst_n = 1;

        // R12 reset state
        rd(CTL, 16'h0, "R12 ctl");
        rd(STAT, 16'h0, "R12 status");
        rd(maddr(2'b11, 1, 1, 3'd7), 16'h0, "R12 map");

        // R8 translation off
        do_req(1, 16'h1234, 1, 1, 2'b11, 0, "R8 low");
        do_req(1, 16'hDFFF, 0, 0, 2'b00, 0, "R8 edge");
        do_req(1, 16'hE000, 0, 0, 2'b01, 0, "R8 top");
        do_req(1, 16'hFFFF, 1, 0, 2'b10, 0, "R8 badmode");
        wr(CTL, 16'h0002);
        do_req(1, 16'hE123, 0, 1, 2'b00, 0, "R8 wide top");

        // R11 register map, readback, ignored mode
        wr(maddr(2'b10, 0, 0, 3'd3), 16'hBEEF);
        rd(maddr(2'b10, 0, 0, 3'd3), 16'h0, "R11 ignored mode");
        wr(maddr(2'b00, 0, 0, 3'd0), 16'h0FFF);
        wr(maddr(2'b00, 0, 1, 3'd0), 16'h7F06);
        rd(maddr(2'b00, 0, 0, 3'd0), 16'h0FFF, "R11 base readback");
        rd(maddr(2'b00, 0, 1, 3'd0), 16'h7F06, "R11 desc readback");
        wr(CTL, 16'h0001);
        rd(CTL, 16'h0001, "R11 ctl readback");
        do_req(1, 16'h0040, 0, 0, 2'b00, 0, "R1 R11 narrow wrap");
        wr(CTL, 16'h0003);
        do_req(1, 16'h0040, 0, 0, 2'b00, 0, "R2 wide carry");
        wr(maddr(2'b00, 0, 0, 3'd0), 16'hFFF0);
        do_req(1, 16'h0805, 0, 0, 2'b00, 0, "R2 R11 wide wrap");
        wr(CTL, 16'h0001);

        // R3 R5 length boundary on page 5
        wr(maddr(2'b00, 0, 0, 3'd5), 16'h0123);
        wr(maddr(2'b00, 0, 1, 3'd5), 16'h0506);
        do_req(1, 16'hA000 | 16'h0140, 1, 0, 2'b00, 0, "R3 R5 len equal");
        do_req(1, 16'hA000 | 16'h0180, 0, 0, 2'b00, 0, "R5 len over");
        wr(STAT, 16'h0);

        // R4 access rights
        wr(maddr(2'b01, 0, 1, 3'd2), 16'h7F02);
        do_req(1, 16'h4000, 0, 0, 2'b01, 0, "R4 ro read");
        do_req(1, 16'h4000, 1, 0, 2'b01, 0, "R4 ro write");
        do_req(1, 16'h4040, 0, 0, 2'b00, 1, "R10 clear wins");
        wr(maddr(2'b01, 0, 1, 3'd2), 16'h7F00);
        do_req(1, 16'h4000, 0, 0, 2'b01, 0, "R4 none read");
        do_req(1, 16'hA000 | 16'h0180, 0, 0, 2'b00, 0, "R10 second held");
        wr(STAT, 16'h0);

        // R9 invalid request ignored
        do_req(0, 16'h4000, 1, 0, 2'b01, 0, "R9 no valid");
        // R6 illegal mode
        do_req(1, 16'h0000, 0, 0, 2'b10, 0, "R6 bad mode");
        wr(STAT, 16'h0);

        // R7 data bank selection for user mode page 1
        wr(maddr(2'b11, 0, 0, 3'd1), 16'h0200);
        wr(maddr(2'b11, 0, 1, 3'd1), 16'h7F06);
        wr(maddr(2'b11, 1, 0, 3'd1), 16'h0400);
        wr(maddr(2'b11, 1, 1, 3'd1), 16'h7F02);
        do_req(1, 16'h2080, 1, 1, 2'b11, 0, "R7 shared bank");
        wr(CTL, 16'h0011);
        do_req(1, 16'h2080, 1, 1, 2'b11, 0, "R6 R7 separate bank");
        wr(STAT, 16'h0);

        // random programming of all banks
        for (int b = 0; b < 4; b++) begin
            if (b == 2) continue;
            for (int s = 0; s < 2; s++)
                for (int p = 0; p < 8; p++) begin
                    wr(maddr(b[1:0], s[0], 0, p[2:0]), 16'($urandom));
                    wr(maddr(b[1:0], s[0], 1, p[2:0]),
                       {1'b0, 7'($urandom), 5'b0, 2'($urandom), 1'b0});
                end
        end
        rd(maddr(2'b01, 1, 1, 3'd6), mdesc[3][6], "R11 random readback");

        for (int i = 0; i < 600; i++) begin
            int r;
            r = $urandom_range(0, 99);
            if (r < 6) begin
                wr(CTL, {11'h0, 3'($urandom), 1'($urandom), 1'b1});
            end else if (r < 12) begin
                wr(maddr(2'($urandom) | 2'b01, 1'($urandom), 1'($urandom), 3'($urandom)),
                   {1'b0, 7'($urandom), 5'b0, 2'($urandom), 1'b0});
            end else begin
                do_req(r > 15, 16'($urandom), 1'($urandom), 1'($urandom),
                       2'($urandom), r > 90, "R1 R2 R3 R4 R5 R6 R7 random");
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule